// File: doc/BRIEF.md
# 24-bit SPI Register Access Slave

This block is a slave-only serial port that gives an external master read and write access to a bank of control registers. A frame opens when the active-low chip select falls and holds 24 bits. The first eight bits are a command byte: its top bit picks the direction and its low seven bits give the register address. The next sixteen bits carry the data word. Both fields are sent most significant bit first.

Serial clock, chip select and data input are brought into the system clock domain through two-flop synchronizers. Edges are then found there, so the serial clock must stay well below the system clock rate.

A write goes out on the register-bank port as a single-cycle strobe. It is issued only once chip select returns high after exactly 24 rising clock edges. On a read, the addressed register is shifted out on falling edges, starting right after the command byte. The serial output has an enable that drops whenever chip select is high. A small internal file holds 12 bits per register for testing, and reads pad its contents with four ones at the top.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset `miso_oe_o` is 0, `reg_we_o` is 0 and `miso_o` is 0.
- R2: A frame with command bit 7 = 0 is a write. Address = command bits 6:0. The next 16 bits, MSB first, are the data. If chip select rises after exactly 24 rising SCLK edges, `reg_we_o` pulses with `reg_addr_o`/`reg_wdata_o` equal to that address and data.
- R3: If chip select rises after fewer than 24 rising edges, no write is issued and the addressed register keeps its value.
- R4: If chip select rises after more than 24 rising edges, no write is issued and the register keeps its value.
- R5: A frame with command bit 7 = 1 is a read. Data bits 15..0 of the addressed register appear on `miso_o` one per falling SCLK edge, starting with the falling edge after the 8th rising edge. The master therefore samples them on rising edges 9 to 24.
- R6: The internal file keeps bits 11:0 of written data. Read bits 15:12 are always 1, so a read returns {4'hF, stored[11:0]}.
- R7: `miso_oe_o` is 1 while chip select is low and drops within four system clocks after chip select rises. A read cut short this way is dropped, and the next frame works normally.
- R8: Pauses in SCLK between bytes inside one chip-select window give the same result as a continuous stream.
- R9: Addresses at or above `NUM_REGS` still strobe the bank port on a write, but the internal file ignores them, and reads of them return 16'hF000.
- R10: `reg_we_o` lasts exactly one system clock cycle per committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from master |
| cs_ni | input | 1 | Active-low chip select |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for serial data out (0 = high impedance) |
| reg_addr_o | output | ADDR_W (7) | Register-bank write address |
| reg_wdata_o | output | DATA_W (16) | Register-bank write data |
| reg_we_o | output | 1 | Register-bank write strobe |

## Verification
The bench uses the default parameters: a 16-entry file of 12-bit registers and a 7-bit address. With these, address 0x40 is out of range while address 15 is the last valid entry, and a written value of 16'hFFFF shows the top four bits being dropped. The SCLK half period is four system clocks. This leaves room for the synchronizer delay and lets both continuous and byte-paused framing be exercised. Frames of 20, 23, 26 and 14 bits cover the short, off-by-one, long and aborted-read edge counts.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } op_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= RST_VAL;
        else         st[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= RST_VAL;
        else         st[g] <= st[g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_reg_pkg::*;
#(
  parameter int unsigned CMD_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_s_i,
  input  logic              cs_s_i,
  input  logic              mosi_s_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              miso_o,
  output logic              oe_o
);
  localparam int unsigned FRAME = CMD_W + DATA_W;
  localparam int unsigned CNT_W = $clog2(FRAME + 2);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] C_SAT   = CNT_W'(FRAME + 1);
  localparam logic [CNT_W-1:0] C_CMD   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] C_CMD_M = CNT_W'(CMD_W - 1);

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  cnt;
  logic [FRAME-1:0]  sh;
  logic [DATA_W-1:0] out_sh;
  logic              is_rd, miso_q, oe_q, we_q;
  logic [ADDR_W-1:0] wa_q;
  logic [DATA_W-1:0] wd_q;

  logic rise, fall, cs_fall, cs_rise, active;
  logic [CMD_W-1:0] cmd_next;

  assign rise     = sclk_s_i & ~sclk_d;
  assign fall     = ~sclk_s_i & sclk_d;
  assign cs_fall  = ~cs_s_i & cs_d;
  assign cs_rise  = cs_s_i & ~cs_d;
  assign active   = ~cs_s_i;
  assign cmd_next = {sh[CMD_W-2:0], mosi_s_i};
  assign rd_addr_o = cmd_next[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
      out_sh <= '0;
      is_rd  <= 1'b0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      wa_q   <= '0;
      wd_q   <= '0;
    end else begin
      sclk_d <= sclk_s_i;
      cs_d   <= cs_s_i;
      oe_q   <= active;
      we_q   <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        sh     <= '0;
        out_sh <= '0;
        is_rd  <= 1'b0;
        miso_q <= 1'b0;
      end else if (cs_rise) begin
        // commit only on an exact-length write frame
        if (cnt == C_FRAME && op_e'(sh[FRAME-1]) == OP_WR) begin
          we_q <= 1'b1;
          wa_q <= sh[FRAME-2 -: ADDR_W];
          wd_q <= sh[DATA_W-1:0];
        end
        cnt    <= '0;
        is_rd  <= 1'b0;
        miso_q <= 1'b0;
      end else if (active) begin
        if (rise && cnt != C_SAT) begin
          cnt <= cnt + 1'b1;
          if (cnt < C_FRAME) sh <= {sh[FRAME-2:0], mosi_s_i};
          if (cnt == C_CMD_M && op_e'(cmd_next[CMD_W-1]) == OP_RD) begin
            is_rd  <= 1'b1;
            out_sh <= rd_data_i;
          end
        end
        if (fall && is_rd && cnt >= C_CMD && cnt < C_FRAME) begin
          miso_q <= out_sh[DATA_W-1];
          out_sh <= {out_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign wr_en_o   = we_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;
  assign oe_o      = oe_q;
  assign miso_o    = miso_q & oe_q;
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned REG_W    = 12,
  parameter int unsigned DATA_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [ADDR_W-1:0] ra_i,
  output logic [DATA_W-1:0] rd_o
);
  localparam int unsigned PAD   = DATA_W - REG_W;
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [REG_W-1:0] mem [NUM_REGS];
  logic             w_ok, r_ok;
  logic [IDX_W-1:0] widx, ridx;

  assign w_ok = int'(wa_i) < NUM_REGS;
  assign r_ok = int'(ra_i) < NUM_REGS;
  assign widx = wa_i[IDX_W-1:0];
  assign ridx = ra_i[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) mem[g] <= '0;
      else if (we_i && w_ok && widx == IDX_W'(g)) mem[g] <= wd_i[REG_W-1:0];
  end

  assign rd_o = {{PAD{1'b1}}, (r_ok ? mem[ridx] : {REG_W{1'b0}})};
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
  parameter int unsigned CMD_W    = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned REG_W    = 12,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o
);
  logic              sclk_s, cs_s, mosi_s;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;

  spi_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, cs_ni, mosi_i}),
    .q_o    ({sclk_s, cs_s, mosi_s})
  );

  spi_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (sclk_s),
    .cs_s_i    (cs_s),
    .mosi_s_i  (mosi_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_en_o   (reg_we_o),
    .wr_addr_o (reg_addr_o),
    .wr_data_o (reg_wdata_o),
    .miso_o    (miso_o),
    .oe_o      (miso_oe_o)
  );

  spi_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .REG_W(REG_W), .DATA_W(DATA_W)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_o),
    .wa_i   (reg_addr_o),
    .wd_i   (reg_wdata_o),
    .ra_i   (rd_addr),
    .rd_o   (rd_data)
  );
endmodule

// File: rtl/spi_reg_chk.sv
module spi_reg_chk #(
  parameter int unsigned FRAME = 24
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic cs_s,
  input logic sclk_s,
  input logic miso_oe_o,
  input logic reg_we_o
);
  logic       sclk_p, cs_p;
  logic [5:0] n_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= 1'b0;
      cs_p   <= 1'b1;
      n_rise <= '0;
    end else begin
      sclk_p <= sclk_s;
      cs_p   <= cs_s;
      if (!cs_s && cs_p) n_rise <= '0;
      else if (!cs_s && sclk_s && !sclk_p && n_rise != 6'h3f) n_rise <= n_rise + 1'b1;
    end
  end

  p_we_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_after_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> cs_s);

  p_we_exact_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> n_rise == 6'(FRAME));

  p_oe_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !miso_oe_o);
endmodule

bind spi_reg_slave spi_reg_chk #(.FRAME(CMD_W + DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .cs_s      (cs_s),
  .sclk_s    (sclk_s),
  .miso_oe_o (miso_oe_o),
  .reg_we_o  (reg_we_o)
);

// File: tb/sim_spi_reg_slave.sv
`timescale 1ns/1ps
module sim_spi_reg_slave;
  localparam int HP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, we;
  logic [6:0]  waddr;
  logic [15:0] wdata;

  int total = 0, bad = 0;
  logic [22:0] exp_q [$];
  logic [11:0] model [16];
  logic we_prev = 1'b0;

  always #2 clk = ~clk;

  spi_reg_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .reg_addr_o(waddr),
    .reg_wdata_o(wdata), .reg_we_o(we)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected writes as the port strobes
  always @(negedge clk) begin
    if (rst_n) begin
      if (we && we_prev) chk(1'b0, "R10", {31'd0, we}, 32'd0);
      if (we) begin
        if (exp_q.size() == 0) chk(1'b0, "R2/R3/R4 unexpected write", {9'd0, waddr, wdata}, 32'd0);
        else begin
          logic [22:0] e;
          e = exp_q.pop_front();
          chk({waddr, wdata} == e, "R2", {9'd0, waddr, wdata}, {9'd0, e});
        end
      end
      we_prev <= we;
    end
  end

  task automatic frame(input logic [7:0] cmd, input logic [15:0] data, input int nbits,
                       input bit gaps, input string req, output logic [15:0] rx);
    logic [23:0] word;
    word = {cmd, data};
    rx = '0;
    cs_n = 1'b0;
    #(HP);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? word[23-i] : 1'b0;
      #(HP);
      sclk = 1'b1;
      if (i >= 8 && i < 24) rx[23-i] = miso;
      if (i == 4) chk(miso_oe == 1'b1, {req, " R7 oe"}, {31'd0, miso_oe}, 32'd1);
      #(HP);
      sclk = 1'b0;
      if (gaps && (i % 8) == 7) #(5*HP);
    end
    #(HP);
    cs_n = 1'b1;
    #(HP);
    #(HP);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d, input bit gaps);
    logic [15:0] rx;
    exp_q.push_back({a, d});
    if (a < 16) model[a[3:0]] = d[11:0];
    frame({1'b0, a}, d, 24, gaps, "R2", rx);
  endtask

  task automatic rd(input logic [6:0] a, input bit gaps, input string req);
    logic [15:0] rx, e;
    e = {4'hF, (a < 16) ? model[a[3:0]] : 12'h000};
    frame({1'b1, a}, 16'h0000, 24, gaps, req, rx);
    chk(rx == e, req, {16'd0, rx}, {16'd0, e});
  endtask

  initial begin
    logic [15:0] rx;
    for (int i = 0; i < 16; i++) model[i] = '0;
    #21;
    chk(miso_oe == 1'b0 && we == 1'b0 && miso == 1'b0, "R1", {29'd0, miso_oe, we, miso}, 32'd0);
    rst_n = 1'b1;
    #41;
    chk(miso_oe == 1'b0 && we == 1'b0, "R1", {30'd0, miso_oe, we}, 32'd0);

    wr(7'd3, 16'hA5C3, 1'b0);
    rd(7'd3, 1'b0, "R5 R6");
    wr(7'd5, 16'h1234, 1'b1);
    rd(7'd5, 1'b1, "R8");
    rd(7'd0, 1'b0, "R5 zero");

    frame(8'h03, 16'hFFFF, 20, 1'b0, "R3", rx);
    rd(7'd3, 1'b0, "R3");
    frame(8'h03, 16'hFFFF, 23, 1'b0, "R3", rx);
    rd(7'd3, 1'b0, "R3");
    frame(8'h03, 16'hFFFF, 26, 1'b0, "R4", rx);
    rd(7'd3, 1'b0, "R4");

    // read cut short mid-data
    cs_n = 1'b0;
    #(HP);
    for (int i = 0; i < 14; i++) begin
      logic [7:0] c;
      c = 8'h85;
      mosi = (i < 8) ? c[7-i] : 1'b0;
      #(HP); sclk = 1'b1; #(HP); sclk = 1'b0;
    end
    #(HP);
    cs_n = 1'b1;
    #20;
    chk(miso_oe == 1'b0, "R7 abort", {31'd0, miso_oe}, 32'd0);
    #(2*HP);
    rd(7'd5, 1'b0, "R7 after abort");

    wr(7'd15, 16'hFFFF, 1'b0);
    rd(7'd15, 1'b0, "R6 top bits");
    wr(7'h40, 16'h0ABC, 1'b0);
    rd(7'h40, 1'b0, "R9");
    rd(7'd0, 1'b0, "R9 alias");
    wr(7'd0, 16'h0001, 1'b1);
    rd(7'd0, 1'b0, "R8 R2");

    #(4*HP);
    chk(exp_q.size() == 0, "R2 missing write", exp_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule